// File: doc/BRIEF.md
# Banked SPI Register Command Slave

This block is the SPI-side front end of a network controller. An external host drives a mode 0 SPI link (clock idles low, data sampled on the rising edge, changed on the falling edge). Each chip-select frame begins with one command byte. That byte selects one of several actions: a register read, a register write, a masked bit set or bit clear, a streamed transfer into or out of packet buffer memory, or a soft reset. The block holds the control registers itself, in four banks of 27 banked addresses plus five addresses shared by every bank. It also holds a byte-wide buffer RAM of 2^BUF_AW bytes.

Two bits of a shared control register pick the active bank. Two 16-bit pointers, each kept as a low byte and a high byte, give the buffer locations for streamed reads and writes. Each streamed byte moves its pointer on by one, so the host can move a whole packet under a single chip select. Registers in the MAC and MII class are plain storage. The only thing they copy from real MAC registers is their read timing: a read of one returns a dummy byte before the data.

The block samples the SPI pins with the system clock. The pins must already be synchronous to `clk`, and each SPI clock level must last at least three system clock cycles.

Top module: `spi_regbank`

## Requirements
- R1: The first byte of a frame holds the opcode in bits 7:5 and the register address in bits 4:0. Opcode 000 reads a register. For a register outside the MAC class, the data comes back in the byte right after the command. Every later byte of that frame returns 0x00.
- R2: Opcode 010 writes the second byte of the frame into the addressed register. Any byte after the second is ignored.
- R3: Opcode 100 ORs the second byte into the register as a mask. Opcode 101 ANDs the register with the inverse of the second byte.
- R4: Bits 1:0 of the shared register at address 0x1F select the active bank for addresses 0x00 to 0x1A. Addresses 0x1B to 0x1F reach the same five registers whatever the bank.
- R5: A read of a MAC-class register returns 0x00 first and the register value in the byte after that. The MAC class is bank 2 addresses 0x00 to 0x1A, and bank 3 addresses 0x00 to 0x05.
- R6: A bit set or bit clear aimed at a MAC-class register leaves that register unchanged.
- R7: In bank 0, addresses 0x00 and 0x01 hold the low and high bytes of the buffer read pointer. Addresses 0x02 and 0x03 hold the low and high bytes of the buffer write pointer. Each pointer counts through the full 16 bits. The buffer address is the pointer's low BUF_AW bits.
- R8: Command byte 0x7A opens a write stream. Each later complete byte is stored at the write pointer, and the write pointer then goes up by one.
- R9: Command byte 0x3A opens a read stream. Each later byte returns the buffer byte at the read pointer, and the read pointer goes up by one for every complete byte.
- R10: Command byte 0xFF returns every register to 0x00, which makes bank 0 active and sets both pointers to zero. Buffer RAM contents are kept.
- R11: A rise of chip select ends the command at once. A partial byte is discarded and writes nothing, and both pointers keep their values.
- R12: While chip select is high, MISO is 0. Response bytes go out most significant bit first.
- R13: After the reset input, every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock, mode 0, synchronous to clk |
| spi_cs_n | input | 1 | Active-low chip select, one command per low period |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 while deselected |

## Verification
The bench builds the block with BUF_AW = 4, a buffer of 16 bytes. With that size, a stream can cover every buffer location and run past the top, so wrap-around of the buffer address is exercised. The same streams also carry the pointers across a low-byte boundary, from 0x00FF to 0x0100. The bench writes a computed pattern to every address of every bank and then reads each one back. Shared, ordinary and MAC-class addresses are therefore all checked against an arithmetic model in the bench.

// File: rtl/spi_regbank_pkg.sv
// Package: shared constants, command encodings, FSM type and the
// MAC-class address decode used by the banked SPI register slave.
package spi_regbank_pkg;

    localparam int NUM_BANKS      = 4;
    localparam int BANK_W         = $clog2(NUM_BANKS);
    localparam int ADDR_W         = 5;
    localparam int BANKED_REGS    = 27;                 // 0x00..0x1A per bank
    localparam int SHARED_REGS    = 32 - BANKED_REGS;   // 0x1B..0x1F common
    localparam int SH_IDX_W       = $clog2(SHARED_REGS);
    localparam int PTR_W          = 16;

    localparam logic [2:0] OP_RD  = 3'b000;
    localparam logic [2:0] OP_WR  = 3'b010;
    localparam logic [2:0] OP_BFS = 3'b100;
    localparam logic [2:0] OP_BFC = 3'b101;

    localparam logic [7:0] CMD_BUF_RD = 8'h3A;
    localparam logic [7:0] CMD_BUF_WR = 8'h7A;
    localparam logic [7:0] CMD_SRST   = 8'hFF;

    // Pointer byte locations inside bank 0
    localparam int RDPTR_LO = 0;
    localparam int RDPTR_HI = 1;
    localparam int WRPTR_LO = 2;
    localparam int WRPTR_HI = 3;

    // MAC class: whole banked part of bank 2, low part of bank 3
    localparam logic [BANK_W-1:0] MAC_BANK_FULL  = 2'd2;
    localparam logic [BANK_W-1:0] MAC_BANK_PART  = 2'd3;
    localparam logic [ADDR_W-1:0] MAC_PART_LIMIT = 5'd6;

    typedef enum logic [2:0] {
        S_CMD, S_RD_DUMMY, S_WR, S_BFS, S_BFC, S_BRD, S_BWR, S_IGNORE
    } cmd_state_e;

    // True when bank/address names a register with dummy-byte read timing
    function automatic logic is_mac_class(input logic [BANK_W-1:0] bank,
                                          input logic [ADDR_W-1:0] addr);
        return ((bank == MAC_BANK_FULL) && (addr < ADDR_W'(BANKED_REGS))) ||
               ((bank == MAC_BANK_PART) && (addr < MAC_PART_LIMIT));
    endfunction

endpackage

// File: rtl/spi_mode0_shifter.sv
// SPI mode 0 byte shifter running on the system clock.
// Assumes sck/cs_n/mosi are synchronous to clk and each sck level lasts
// at least three clk cycles. Deselect clears all partial state.
// A byte loaded through tx_wr goes out on the next byte boundary.
module spi_mode0_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sck,
    input  logic         cs_n,
    input  logic         mosi,
    output logic         miso,
    output logic         byte_done,
    output logic [W-1:0] rx_byte,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_data
);
    localparam int CNT_W = $clog2(W);

    logic             sck_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     rx_sh;
    logic [W-1:0]     tx_sh;
    logic [W-1:0]     tx_hold;
    logic             rise, fall;

    assign rise = !cs_n && sck && !sck_q;
    assign fall = !cs_n && !sck && sck_q;

    // Previous SPI clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    // Receive side: sample MOSI on rising edges, flag each full byte
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sh   <= {rx_sh[W-2:0], mosi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(W - 1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh[W-2:0], mosi};
                end
            end
        end
    end

    // Transmit side: load on the falling edge at a byte boundary, else shift
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            tx_sh   <= '0;
            tx_hold <= '0;
        end else begin
            if (tx_wr) tx_hold <= tx_data;
            if (fall) begin
                if (bit_cnt == '0) tx_sh <= tx_wr ? tx_data : tx_hold;
                else               tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
        end
    end

    assign miso = !cs_n && tx_sh[W-1];

endmodule

// File: rtl/banked_regfile.sv
// Banked control register storage: NUM_BANKS banks of BANKED_REGS bytes
// plus SHARED_REGS bytes visible from every bank. The last shared byte
// selects the bank. Bank 0 holds the two 16-bit stream pointers, which
// also take increment requests. Reset and soft reset clear everything.
module banked_regfile
    import spi_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              inc_rd,
    input  logic              inc_wr,
    output logic [BANK_W-1:0] cur_bank,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  wr_ptr
);
    logic [7:0] bank_mem [NUM_BANKS][BANKED_REGS];
    logic [7:0] shared_mem [SHARED_REGS];

    logic [SH_IDX_W-1:0] rd_sh_idx, wr_sh_idx;
    logic                rd_is_sh, wr_is_sh;

    assign rd_is_sh  = rd_addr >= ADDR_W'(BANKED_REGS);
    assign wr_is_sh  = wr_addr >= ADDR_W'(BANKED_REGS);
    assign rd_sh_idx = SH_IDX_W'(rd_addr - ADDR_W'(BANKED_REGS));
    assign wr_sh_idx = SH_IDX_W'(wr_addr - ADDR_W'(BANKED_REGS));

    assign cur_bank = shared_mem[SHARED_REGS-1][BANK_W-1:0];
    assign rd_ptr   = {bank_mem[0][RDPTR_HI], bank_mem[0][RDPTR_LO]};
    assign wr_ptr   = {bank_mem[0][WRPTR_HI], bank_mem[0][WRPTR_LO]};

    // Read mux: shared window first, else the active bank
    always_comb begin
        if (rd_is_sh) rd_data = shared_mem[rd_sh_idx];
        else          rd_data = bank_mem[cur_bank][rd_addr];
    end

    // Storage update: clear, host write, pointer increments
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            for (int b = 0; b < NUM_BANKS; b++)
                for (int a = 0; a < BANKED_REGS; a++)
                    bank_mem[b][a] <= 8'h00;
            for (int s = 0; s < SHARED_REGS; s++)
                shared_mem[s] <= 8'h00;
        end else begin
            if (wr_en) begin
                if (wr_is_sh) shared_mem[wr_sh_idx] <= wr_data;
                else          bank_mem[cur_bank][wr_addr] <= wr_data;
            end
            if (inc_rd)
                {bank_mem[0][RDPTR_HI], bank_mem[0][RDPTR_LO]} <= rd_ptr + 1'b1;
            if (inc_wr)
                {bank_mem[0][WRPTR_HI], bank_mem[0][WRPTR_LO]} <= wr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/pkt_buffer_ram.sv
// Byte-wide packet buffer of 2^AW bytes: one synchronous write port and
// one combinational read port. Contents are not cleared by any reset.
module pkt_buffer_ram #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/spi_regbank.sv
// Top: SPI command slave over a banked register file and packet buffer.
// Decodes the first byte of each chip-select frame and runs one command
// per frame. Assumes the SPI pins are synchronous to clk (see shifter).
module spi_regbank
    import spi_regbank_pkg::*;
#(
    parameter int BUF_AW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    logic              byte_done;
    logic [7:0]        rx_byte;
    logic              tx_wr;
    logic [7:0]        tx_data;

    cmd_state_e        state, state_n;
    logic [ADDR_W-1:0] addr_q, addr_n;

    logic [ADDR_W-1:0] reg_rd_addr;
    logic [7:0]        reg_rd_data;
    logic              reg_wr_en;
    logic [7:0]        reg_wr_data;
    logic              inc_rd, inc_wr, soft_rst;
    logic [BANK_W-1:0] cur_bank;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;

    logic              ram_we;
    logic [BUF_AW-1:0] ram_raddr;
    logic [7:0]        ram_rdata;

    logic [2:0]        cmd_op;
    logic [ADDR_W-1:0] cmd_addr;

    assign cmd_op   = rx_byte[7:5];
    assign cmd_addr = rx_byte[4:0];

    spi_mode0_shifter #(.W(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .miso(spi_miso), .byte_done(byte_done),
        .rx_byte(rx_byte), .tx_wr(tx_wr), .tx_data(tx_data)
    );

    banked_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .wr_en(reg_wr_en), .wr_addr(addr_q), .wr_data(reg_wr_data),
        .inc_rd(inc_rd), .inc_wr(inc_wr), .cur_bank(cur_bank),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
    );

    pkt_buffer_ram #(.AW(BUF_AW)) u_buf (
        .clk(clk), .we(ram_we), .waddr(wr_ptr[BUF_AW-1:0]),
        .wdata(rx_byte), .raddr(ram_raddr), .rdata(ram_rdata)
    );

    // Command byte fetches the pointer location; stream bytes prefetch the next
    assign ram_raddr   = (state == S_CMD) ? rd_ptr[BUF_AW-1:0]
                                          : BUF_AW'(rd_ptr + 1'b1);
    assign reg_rd_addr = (state == S_CMD) ? cmd_addr : addr_q;

    // Frame state: back to command decode whenever chip select is high
    always_ff @(posedge clk) begin
        if (!rst_n || spi_cs_n) begin
            state  <= S_CMD;
            addr_q <= '0;
        end else begin
            state  <= state_n;
            addr_q <= addr_n;
        end
    end

    // Per-byte command actions and next response byte
    always_comb begin
        state_n     = state;
        addr_n      = addr_q;
        tx_wr       = 1'b0;
        tx_data     = 8'h00;
        reg_wr_en   = 1'b0;
        reg_wr_data = rx_byte;
        inc_rd      = 1'b0;
        inc_wr      = 1'b0;
        ram_we      = 1'b0;
        soft_rst    = 1'b0;
        if (byte_done) begin
            tx_wr = 1'b1;
            unique case (state)
                S_CMD: begin
                    addr_n = cmd_addr;
                    if (rx_byte == CMD_BUF_RD) begin
                        tx_data = ram_rdata;
                        state_n = S_BRD;
                    end else if (rx_byte == CMD_BUF_WR) begin
                        state_n = S_BWR;
                    end else if (rx_byte == CMD_SRST) begin
                        soft_rst = 1'b1;
                        state_n  = S_IGNORE;
                    end else begin
                        case (cmd_op)
                            OP_RD: begin
                                if (is_mac_class(cur_bank, cmd_addr)) begin
                                    state_n = S_RD_DUMMY;
                                end else begin
                                    tx_data = reg_rd_data;
                                    state_n = S_IGNORE;
                                end
                            end
                            OP_WR:   state_n = S_WR;
                            OP_BFS:  state_n = is_mac_class(cur_bank, cmd_addr) ? S_IGNORE : S_BFS;
                            OP_BFC:  state_n = is_mac_class(cur_bank, cmd_addr) ? S_IGNORE : S_BFC;
                            default: state_n = S_IGNORE;
                        endcase
                    end
                end
                S_RD_DUMMY: begin
                    tx_data = reg_rd_data;
                    state_n = S_IGNORE;
                end
                S_WR: begin
                    reg_wr_en = 1'b1;
                    state_n   = S_IGNORE;
                end
                S_BFS: begin
                    reg_wr_en   = 1'b1;
                    reg_wr_data = reg_rd_data | rx_byte;
                    state_n     = S_IGNORE;
                end
                S_BFC: begin
                    reg_wr_en   = 1'b1;
                    reg_wr_data = reg_rd_data & ~rx_byte;
                    state_n     = S_IGNORE;
                end
                S_BRD: begin
                    inc_rd  = 1'b1;
                    tx_data = ram_rdata;
                end
                S_BWR: begin
                    ram_we = 1'b1;
                    inc_wr = 1'b1;
                end
                S_IGNORE: begin
                    tx_data = 8'h00;
                end
                default: state_n = S_IGNORE;
            endcase
        end
    end

endmodule

// File: rtl/spi_regbank_chk.sv
// Checker for spi_regbank: temporal properties over pointer, bank,
// soft-reset and chip-select behaviour. Attached by bind below.
module spi_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        byte_done,
    input logic [1:0]  bank,
    input logic [15:0] rd_ptr,
    input logic [15:0] wr_ptr,
    input logic        inc_rd,
    input logic        inc_wr,
    input logic        soft_rst,
    input logic        reg_wr_en,
    input logic        ram_we
);
    assert_bank_needs_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank != $past(bank)) |-> $past(byte_done));

    assert_rdptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_rd |=> (rd_ptr == $past(rd_ptr) + 16'd1));

    assert_wrptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc_wr |=> (wr_ptr == $past(wr_ptr) + 16'd1));

    assert_no_write_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!reg_wr_en && !ram_we));

    assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_rd && !inc_wr && !reg_wr_en && !soft_rst) |=>
            ($stable(rd_ptr) && $stable(wr_ptr)));

    assert_soft_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank == 2'd0 && rd_ptr == 16'd0 && wr_ptr == 16'd0));

endmodule

bind spi_regbank spi_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .byte_done(byte_done),
    .bank(cur_bank), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .inc_rd(inc_rd), .inc_wr(inc_wr), .soft_rst(soft_rst),
    .reg_wr_en(reg_wr_en), .ram_we(ram_we)
);

// File: tb/spi_regbank_bench.sv
// Bench for spi_regbank with a 16-byte buffer: full register sweeps,
// bit-field ops, streams with wrap and carry, aborts and soft reset.
module spi_regbank_bench;
    localparam int BUF_AW = 4;
    localparam int BUF_N  = 1 << BUF_AW;
    localparam int H      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int errors = 0;

    logic [7:0] mdl_bk [4][27];
    logic [7:0] mdl_sh [5];
    logic [7:0] bufm [BUF_N];

    always #2.5 clk = ~clk;

    spi_regbank #(.BUF_AW(BUF_AW)) u_spi_regbank (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic mac_b(input int b, input int a);
        return (b == 2 && a < 27) || (b == 3 && a < 6);
    endfunction

    function automatic logic [7:0] pat(input int b, input int a);
        return 8'((b * 53 + a * 7 + 27) & 255);
    endfunction

    function automatic int mbank();
        return int'(mdl_sh[4][1:0]);
    endfunction

    function automatic logic [7:0] mget(input int a);
        if (a >= 27) return mdl_sh[a-27];
        return mdl_bk[mbank()][a];
    endfunction

    task automatic mset(input int a, input logic [7:0] v);
        if (a >= 27) mdl_sh[a-27] = v;
        else         mdl_bk[mbank()][a] = v;
    endtask

    task automatic mclear();
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 27; a++) mdl_bk[b][a] = 8'h00;
        for (int s = 0; s < 5; s++) mdl_sh[s] = 8'h00;
    endtask

    task automatic cs_begin();
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*H) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] t, input int n, output logic [7:0] r);
        r = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = t[i];
            repeat (H) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] t, output logic [7:0] r);
        xbits(t, 8, r);
    endtask

    task automatic wr_reg(input int a, input logic [7:0] v);
        logic [7:0] r;
        cs_begin(); xfer({3'b010, 5'(a)}, r); xfer(v, r); cs_end();
        mset(a, v);
    endtask

    task automatic bf_op(input logic [2:0] op, input int a, input logic [7:0] m);
        logic [7:0] r;
        cs_begin(); xfer({op, 5'(a)}, r); xfer(m, r); cs_end();
    endtask

    task automatic rd_reg(input int a, output logic [7:0] v);
        logic [7:0] d;
        cs_begin();
        xfer({3'b000, 5'(a)}, d);
        if (mac_b(mbank(), a)) begin
            xfer(8'h00, d);
            chk("R5 dummy byte", d, 8'h00);
        end
        xfer(8'h00, v);
        cs_end();
    endtask

    task automatic set_bank(input int b);
        wr_reg(31, 8'(b));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, r;
        mclear();
        for (int i = 0; i < BUF_N; i++) bufm[i] = 8'h00;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R12: idle output, R13: reset contents
        chk("R12 miso idle low", {7'd0, miso}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd_reg(a, v); chk("R13 pointer byte after reset", v, 8'h00);
        end
        rd_reg(31, v); chk("R13 bank select after reset", v, 8'h00);

        // R1 R2 R4 R5: write every address of every bank, then read back
        for (int b = 0; b < 4; b++) begin
            set_bank(b);
            for (int a = 0; a < 31; a++) wr_reg(a, pat(b, a));
        end
        for (int b = 0; b < 4; b++) begin
            set_bank(b);
            for (int a = 0; a < 32; a++) begin
                rd_reg(a, v);
                if (a >= 27)          chk("R4 shared register", v, mget(a));
                else if (mac_b(b, a)) chk("R5 MAC-class data", v, mget(a));
                else                  chk("R1 banked register", v, mget(a));
            end
        end
        chk("R12 miso idle after frames", {7'd0, miso}, 8'h00);

        // R1: bytes after the data byte return 0
        set_bank(1);
        cs_begin(); xfer(8'h08, r); xfer(8'h00, v); xfer(8'h00, r); cs_end();
        chk("R1 read data", v, mget(8));
        chk("R1 trailing byte zero", r, 8'h00);

        // R2: extra bytes after the write data are ignored
        cs_begin(); xfer(8'h46, r); xfer(8'hAA, r); xfer(8'h55, r); xfer(8'h66, r); cs_end();
        mset(6, 8'hAA);
        rd_reg(6, v); chk("R2 extra bytes ignored", v, 8'hAA);

        // R3: bit set and bit clear, walking masks
        wr_reg(7, 8'h00);
        for (int k = 0; k < 8; k++) begin
            bf_op(3'b100, 7, 8'(1 << k));
            rd_reg(7, v); chk("R3 bit set", v, 8'((2 << k) - 1));
        end
        for (int k = 0; k < 8; k++) begin
            bf_op(3'b101, 7, 8'(1 << k));
            rd_reg(7, v); chk("R3 bit clear", v, 8'(8'hFF << (k + 1)));
        end
        wr_reg(7, 8'h0F);
        bf_op(3'b100, 7, 8'hF0); rd_reg(7, v); chk("R3 set mask F0", v, 8'hFF);
        bf_op(3'b101, 7, 8'h3C); rd_reg(7, v); chk("R3 clear mask 3C", v, 8'hC3);

        // R4: bank switch through a bit set on the shared select register
        bf_op(3'b100, 31, 8'h02);
        mdl_sh[4] = 8'h03;
        rd_reg(31, v); chk("R4 bank select via set", v, 8'h03);
        rd_reg(10, v); chk("R4 bank 3 contents", v, pat(3, 10));

        // R6: bit ops on MAC-class registers have no effect
        wr_reg(5, 8'hA5);
        bf_op(3'b101, 5, 8'hFF); rd_reg(5, v); chk("R6 clear on MAC class", v, 8'hA5);
        wr_reg(6, 8'h10);
        bf_op(3'b100, 6, 8'h01); rd_reg(6, v); chk("R6 set on bank 3 0x06 works", v, 8'h11);
        set_bank(2);
        wr_reg(3, 8'h5A);
        bf_op(3'b100, 3, 8'hFF); rd_reg(3, v); chk("R6 set on MAC class", v, 8'h5A);

        // R11: aborted command byte and aborted data byte
        set_bank(1);
        wr_reg(4, 8'h11);
        cs_begin(); xfer(8'h44, r); xbits(8'hEE, 5, r); cs_end();
        rd_reg(4, v); chk("R11 partial data byte discarded", v, 8'h11);
        cs_begin(); xbits(8'h44, 4, r); cs_end();
        wr_reg(4, 8'h22);
        rd_reg(4, v); chk("R11 decode restarts after abort", v, 8'h22);

        // R8 R7: write stream wrapping the buffer end
        set_bank(0);
        wr_reg(2, 8'h0E); wr_reg(3, 8'h00);
        cs_begin(); xfer(8'h7A, r);
        for (int i = 0; i < 6; i++) begin
            xfer(8'hC0 + 8'(i), r);
            bufm[(14 + i) % BUF_N] = 8'hC0 + 8'(i);
        end
        cs_end();
        rd_reg(2, v); chk("R8 write pointer low after 6", v, 8'h14);
        rd_reg(3, v); chk("R8 write pointer high after 6", v, 8'h00);

        // R9: read stream over the same wrapped span
        wr_reg(0, 8'h0E); wr_reg(1, 8'h00);
        cs_begin(); xfer(8'h3A, r);
        for (int i = 0; i < 6; i++) begin
            xfer(8'h00, v); chk("R9 stream byte", v, bufm[(14 + i) % BUF_N]);
        end
        cs_end();
        rd_reg(0, v); chk("R9 read pointer low after 6", v, 8'h14);

        // R8 R9: whole-buffer sweep
        wr_reg(2, 8'h00); wr_reg(0, 8'h00);
        cs_begin(); xfer(8'h7A, r);
        for (int i = 0; i < BUF_N; i++) begin
            bufm[i] = 8'((i * 29 + 3) & 255);
            xfer(bufm[i], r);
        end
        cs_end();
        cs_begin(); xfer(8'h3A, r);
        for (int i = 0; i < BUF_N; i++) begin
            xfer(8'h00, v); chk("R9 sweep byte", v, bufm[i]);
        end
        cs_end();
        rd_reg(0, v); chk("R9 read pointer after sweep", v, 8'(BUF_N));

        // R7: 16-bit carry from 0x00FF, buffer address from low bits
        wr_reg(2, 8'hFF); wr_reg(3, 8'h00);
        cs_begin(); xfer(8'h7A, r); xfer(8'h81, r); xfer(8'h82, r); cs_end();
        bufm[BUF_N-1] = 8'h81; bufm[0] = 8'h82;
        rd_reg(2, v); chk("R7 pointer low carry", v, 8'h01);
        rd_reg(3, v); chk("R7 pointer high carry", v, 8'h01);
        wr_reg(0, 8'hFF); wr_reg(1, 8'h00);
        cs_begin(); xfer(8'h3A, r); xfer(8'h00, v); xfer(8'h00, r); cs_end();
        chk("R7 byte at 0x00FF", v, 8'h81);
        chk("R7 byte at 0x0100", r, 8'h82);

        // R11: partial stream byte writes nothing, pointer keeps count
        wr_reg(2, 8'h05); wr_reg(3, 8'h00);
        cs_begin(); xfer(8'h7A, r); xfer(8'h99, r); xbits(8'h77, 3, r); cs_end();
        bufm[5] = 8'h99;
        rd_reg(2, v); chk("R11 write pointer after partial", v, 8'h06);
        wr_reg(0, 8'h05); wr_reg(1, 8'h00);
        cs_begin(); xfer(8'h3A, r); xfer(8'h00, v); xfer(8'h00, r); cs_end();
        chk("R11 full byte stored", v, 8'h99);
        chk("R11 partial byte not stored", r, bufm[6]);

        // R10: soft reset clears registers, keeps buffer
        set_bank(1);
        cs_begin(); xfer(8'hFF, r); cs_end();
        mclear();
        rd_reg(31, v); chk("R10 bank select cleared", v, 8'h00);
        rd_reg(0, v);  chk("R10 read pointer cleared", v, 8'h00);
        rd_reg(2, v);  chk("R10 write pointer cleared", v, 8'h00);
        rd_reg(28, v); chk("R10 shared register cleared", v, 8'h00);
        set_bank(1);
        rd_reg(6, v);  chk("R10 bank 1 register cleared", v, 8'h00);
        set_bank(0);
        cs_begin(); xfer(8'h3A, r);
        for (int i = 0; i < BUF_N; i++) begin
            xfer(8'h00, v); chk("R10 buffer kept", v, bufm[i]);
        end
        cs_end();
        chk("R12 miso idle at end", {7'd0, miso}, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule